// File: doc/BRIEF.md
# Aliased General Register File

This block holds eight 32-bit general registers, numbered 0 through 7. Each register can be reached through several views of different widths. The view is picked by a 2-bit size code that comes with each register selector.

- Every register has a full 32-bit view and a low 16-bit view.
- Only registers 0 to 3 also have two 8-bit views: the lowest byte, and the byte just above it.
- The upper 16 bits have no view of their own. They can only be reached through the full view.

The block has one write port and two independent read ports.

- **Write port.** A write to a narrow view replaces only the bits of that view. Every other bit of the 32-bit register keeps its value.
- **Read ports.** Each read port returns the selected view, shifted down to bit 0 and zero-extended to 32 bits.
- **Illegal selections.** A selection that names a view which does not exist is flagged on the port that made it. A flagged write changes nothing.

The block is meant to sit behind operand decode in a datapath. Decode turns an operand name into a register number and a size code, and this block does all of the merging and extracting.

Top module: `gpr_alias_file`

## Requirements
- R1: There are eight 32-bit registers, selected by a 3-bit index 0..7; a full-view write (size code 0) replaces all 32 bits, and a full-view read returns all 32 bits.
- R2: Size code 1 selects bits 15:0 of any of the eight registers; no size code reaches bits 31:16 alone.
- R3: Size code 2 selects bits 7:0 and size code 3 selects bits 15:8, and both are legal only for registers 0 to 3.
- R4: A write to a 16-bit or 8-bit view takes its value from the low bits of wr_data (bits 15:0 or bits 7:0) and leaves every other bit of the target register unchanged.
- R5: A write with wr_en high to an illegal view raises wr_err in the same cycle and leaves all registers unchanged.
- R6: Each read port returns the selected view shifted to bit 0 with all higher bits zero.
- R7: A read of an illegal view raises that port's error flag and returns zero; the two read ports decode and report independently.
- R8: A write takes effect at the rising clock edge; a read of the same register in the same cycle returns the value held before the write.
- R9: An asynchronous active-low reset clears all eight registers to zero.
- R10: With wr_en low, no register changes and wr_err stays low, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Write register index |
| wr_size | input | 2 | Write view code (0 full, 1 low 16, 2 low byte, 3 second byte) |
| wr_data | input | 32 | Write value, aligned to bit 0 |
| wr_err | output | 1 | Write targets a view that does not exist |
| rd0_sel | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 view code |
| rd0_data | output | 32 | Read port 0 view, zero-extended |
| rd0_err | output | 1 | Read port 0 selection does not exist |
| rd1_sel | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 view code |
| rd1_data | output | 32 | Read port 1 view, zero-extended |
| rd1_err | output | 1 | Read port 1 selection does not exist |

## Verification
The hardest case to bring about is showing that a write to a narrow view, or a rejected write, left the untouched bits exactly as they were. Nothing at the ports reports the bits a write did not touch.

To expose them, the stimulus first fills a register with a full-width pattern whose every byte is different. It then writes one view at a time and reads the whole register back through the second read port on the following cycle. The same pattern is used for illegal and disabled writes, which must leave the full-width readback identical.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // View code carried with every register selector.
  typedef enum logic [1:0] {
    VIEW_FULL = 2'd0,
    VIEW_HALF = 2'd1,
    VIEW_LO8  = 2'd2,
    VIEW_HI8  = 2'd3
  } view_e;

  localparam int unsigned GPR_XLEN       = 32;
  localparam int unsigned GPR_NREGS      = 8;
  localparam int unsigned GPR_NBYTE_REGS = 4;
  localparam int unsigned GPR_BYTE_W     = 8;

endpackage

// File: rtl/gpr_view_decode.sv
// Turns (register index, view code) into a legality flag, a bit mask and
// the shift that moves the view down to bit 0.
module gpr_view_decode
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN       = GPR_XLEN,
  parameter int unsigned NREGS      = GPR_NREGS,
  parameter int unsigned NBYTE_REGS = GPR_NBYTE_REGS,
  parameter int unsigned BYTE_W     = GPR_BYTE_W,
  parameter int unsigned SELW       = $clog2(NREGS),
  parameter int unsigned SHW        = $clog2(XLEN)
) (
  input  logic [SELW-1:0] sel,
  input  view_e           size,
  output logic            legal,
  output logic [XLEN-1:0] mask,
  output logic [SHW-1:0]  shamt
);

  localparam int unsigned HALF_W = XLEN / 2;
  localparam logic [XLEN-1:0] HALF_MASK = (XLEN'(1) << HALF_W) - XLEN'(1);
  localparam logic [XLEN-1:0] BYTE_MASK = (XLEN'(1) << BYTE_W) - XLEN'(1);

  logic byte_capable;

  always_comb begin
    byte_capable = (32'(sel) < NBYTE_REGS);
  end

  always_comb begin
    legal = 1'b1;
    mask  = '1;
    shamt = '0;
    unique case (size)
      VIEW_FULL: begin
        mask = '1;
      end
      VIEW_HALF: begin
        mask = HALF_MASK;
      end
      VIEW_LO8: begin
        legal = byte_capable;
        mask  = BYTE_MASK;
      end
      VIEW_HI8: begin
        legal = byte_capable;
        mask  = BYTE_MASK << BYTE_W;
        shamt = SHW'(BYTE_W);
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gpr_write_merge.sv
// Lays a bit-0 aligned value into a view of an existing word.
module gpr_write_merge #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] view_data,
  input  logic [XLEN-1:0] mask,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] new_word
);

  logic [XLEN-1:0] placed;

  always_comb begin
    placed   = (view_data << shamt) & mask;
    new_word = (old_word & ~mask) | placed;
  end

endmodule

// File: rtl/gpr_read_extract.sv
// Pulls a view out of a word, moves it to bit 0 and zero-extends it.
module gpr_read_extract #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] word,
  input  logic [XLEN-1:0] mask,
  input  logic [SHW-1:0]  shamt,
  input  logic            legal,
  output logic [XLEN-1:0] view
);

  always_comb begin
    if (legal) begin
      view = (word & mask) >> shamt;
    end else begin
      view = '0;
    end
  end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN       = GPR_XLEN,
  parameter int unsigned NREGS      = GPR_NREGS,
  parameter int unsigned NBYTE_REGS = GPR_NBYTE_REGS,
  parameter int unsigned SELW       = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [1:0]      wr_size,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_err,
  input  logic [SELW-1:0] rd0_sel,
  input  logic [1:0]      rd0_size,
  output logic [XLEN-1:0] rd0_data,
  output logic            rd0_err,
  input  logic [SELW-1:0] rd1_sel,
  input  logic [1:0]      rd1_size,
  output logic [XLEN-1:0] rd1_data,
  output logic            rd1_err
);

  localparam int unsigned SHW   = $clog2(XLEN);
  localparam int unsigned NRD   = 2;

  // ---------------- storage ----------------
  logic [XLEN-1:0] reg_q [NREGS];
  logic [XLEN-1:0] reg_d [NREGS];
  logic [NREGS-1:0] reg_ce;

  // ---------------- write path ----------------
  logic            wr_legal;
  logic [XLEN-1:0] wr_mask;
  logic [SHW-1:0]  wr_shamt;
  logic            wr_go;
  logic [XLEN-1:0] wr_old;
  logic [XLEN-1:0] wr_merged;

  gpr_view_decode #(
    .XLEN(XLEN), .NREGS(NREGS), .NBYTE_REGS(NBYTE_REGS),
    .BYTE_W(GPR_BYTE_W), .SELW(SELW), .SHW(SHW)
  ) wr_dec_i (
    .sel   (wr_sel),
    .size  (view_e'(wr_size)),
    .legal (wr_legal),
    .mask  (wr_mask),
    .shamt (wr_shamt)
  );

  always_comb begin
    wr_go  = wr_en & wr_legal;
    wr_err = wr_en & ~wr_legal;
    wr_old = reg_q[wr_sel];
  end

  gpr_write_merge #(.XLEN(XLEN), .SHW(SHW)) wr_merge_i (
    .old_word  (wr_old),
    .view_data (wr_data),
    .mask      (wr_mask),
    .shamt     (wr_shamt),
    .new_word  (wr_merged)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    // next-state
    always_comb begin
      reg_ce[g] = wr_go && (wr_sel == SELW'(g));
      reg_d[g]  = wr_merged;
    end

    // register with explicit clock enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_ce[g]) begin
        reg_q[g] <= reg_d[g];
      end
    end
  end

  // ---------------- read ports ----------------
  logic [SELW-1:0] rd_sel   [NRD];
  logic [1:0]      rd_size  [NRD];
  logic [XLEN-1:0] rd_view  [NRD];
  logic            rd_legal [NRD];

  always_comb begin
    rd_sel[0]  = rd0_sel;
    rd_size[0] = rd0_size;
    rd_sel[1]  = rd1_sel;
    rd_size[1] = rd1_size;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XLEN-1:0] mask;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] word;

    gpr_view_decode #(
      .XLEN(XLEN), .NREGS(NREGS), .NBYTE_REGS(NBYTE_REGS),
      .BYTE_W(GPR_BYTE_W), .SELW(SELW), .SHW(SHW)
    ) rd_dec_i (
      .sel   (rd_sel[p]),
      .size  (view_e'(rd_size[p])),
      .legal (rd_legal[p]),
      .mask  (mask),
      .shamt (shamt)
    );

    always_comb begin
      word = reg_q[rd_sel[p]];
    end

    gpr_read_extract #(.XLEN(XLEN), .SHW(SHW)) rd_ext_i (
      .word  (word),
      .mask  (mask),
      .shamt (shamt),
      .legal (rd_legal[p]),
      .view  (rd_view[p])
    );
  end

  always_comb begin
    rd0_data = rd_view[0];
    rd0_err  = ~rd_legal[0];
    rd1_data = rd_view[1];
    rd1_err  = ~rd_legal[1];
  end

endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [SELW-1:0] wr_sel,
  input logic [1:0]      wr_size,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_err,
  input logic [SELW-1:0] rd0_sel,
  input logic [1:0]      rd0_size,
  input logic [XLEN-1:0] rd0_data,
  input logic            rd0_err,
  input logic [SELW-1:0] rd1_sel,
  input logic [1:0]      rd1_size,
  input logic [XLEN-1:0] rd1_data,
  input logic            rd1_err
);

  AST_RD0_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_err |-> (rd0_data == '0)); // R7

  AST_RD1_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_err |-> (rd1_data == '0)); // R7

  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == 2'd1) |-> (rd0_data[XLEN-1:16] == '0)); // R6

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_size[1]) |-> (rd1_data[XLEN-1:8] == '0)); // R6

  AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_size == 2'd0 && rd1_size == 2'd0 && rd1_sel == wr_sel)
    |=> (!(rd1_size == 2'd0 && rd1_sel == $past(rd1_sel)) || rd1_data == $past(wr_data))); // R1

  AST_LOW_BYTE_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_size == 2'd2 && rd1_size == 2'd0 && rd1_sel == wr_sel)
    |=> (!(rd1_size == 2'd0 && rd1_sel == $past(rd1_sel))
         || rd1_data[XLEN-1:8] == $past(rd1_data[XLEN-1:8]))); // R4

  AST_REJECTED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && rd1_size == 2'd0 && rd1_sel == wr_sel)
    |=> (!(rd1_size == 2'd0 && rd1_sel == $past(rd1_sel)) || $stable(rd1_data))); // R5

  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (wr_en && wr_size[1])); // R10

endmodule

bind gpr_alias_file gpr_alias_file_chk #(.XLEN(XLEN), .SELW(SELW)) chk_i (.*);

// File: tb/gpr_alias_file_tb.sv
module gpr_alias_file_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  rd0_sel;
  logic [1:0]  rd0_size;
  logic [31:0] rd0_data;
  logic        rd0_err;
  logic [2:0]  rd1_sel;
  logic [1:0]  rd1_size;
  logic [31:0] rd1_data;
  logic        rd1_err;

  int n_vec;
  int n_bad;

  gpr_alias_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  typedef struct packed {
    logic        en;
    logic [2:0]  wsel;
    logic [1:0]  wsz;
    logic [31:0] wdat;
    logic [2:0]  rsel;
    logic [1:0]  rsz;
    logic [31:0] exp0;
    logic        exp0_err;
    logic        exp_werr;
    logic [31:0] exp1;
  } vec_t;

  localparam int NVEC = 17;

  // Each row: the write inputs, then the read selection for port 0. Port 1
  // reads the same register through its full view. Expected reads show the
  // state before this row's write.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 2'd0, 32'h1234_5678, 3'd0, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R1 R8
    '{1'b1, 3'd0, 2'd2, 32'h0000_00AB, 3'd0, 2'd0, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678}, // R1
    '{1'b1, 3'd0, 2'd3, 32'h0000_00CD, 3'd0, 2'd0, 32'h1234_56AB, 1'b0, 1'b0, 32'h1234_56AB}, // R3 R4
    '{1'b1, 3'd0, 2'd1, 32'hFFFF_BEEF, 3'd0, 2'd3, 32'h0000_00CD, 1'b0, 1'b0, 32'h1234_CDAB}, // R3 R4 R6
    '{1'b1, 3'd5, 2'd0, 32'hCAFE_F00D, 3'd0, 2'd0, 32'h1234_BEEF, 1'b0, 1'b0, 32'h1234_BEEF}, // R2 R4
    '{1'b1, 3'd5, 2'd2, 32'h0000_0011, 3'd5, 2'd0, 32'hCAFE_F00D, 1'b0, 1'b1, 32'hCAFE_F00D}, // R5
    '{1'b1, 3'd5, 2'd1, 32'h0000_2222, 3'd5, 2'd0, 32'hCAFE_F00D, 1'b0, 1'b0, 32'hCAFE_F00D}, // R5
    '{1'b1, 3'd6, 2'd3, 32'h0000_0033, 3'd5, 2'd1, 32'h0000_2222, 1'b0, 1'b1, 32'hCAFE_2222}, // R2 R5
    '{1'b1, 3'd3, 2'd0, 32'hFFFF_FFFF, 3'd5, 2'd2, 32'h0000_0000, 1'b1, 1'b0, 32'hCAFE_2222}, // R7
    '{1'b1, 3'd3, 2'd1, 32'h0000_0000, 3'd3, 2'd3, 32'h0000_00FF, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R6
    '{1'b1, 3'd3, 2'd3, 32'h0000_005A, 3'd3, 2'd0, 32'hFFFF_0000, 1'b0, 1'b0, 32'hFFFF_0000}, // R4
    '{1'b0, 3'd3, 2'd0, 32'h0000_0000, 3'd3, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 32'hFFFF_5A00}, // R10
    '{1'b0, 3'd7, 2'd2, 32'h0000_0077, 3'd3, 2'd3, 32'h0000_005A, 1'b0, 1'b0, 32'hFFFF_5A00}, // R10
    '{1'b1, 3'd7, 2'd2, 32'h0000_0044, 3'd7, 2'd3, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}, // R3 R7
    '{1'b1, 3'd7, 2'd0, 32'h89AB_CDEF, 3'd7, 2'd1, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R8
    '{1'b0, 3'd0, 2'd0, 32'h0000_0000, 3'd7, 2'd1, 32'h0000_CDEF, 1'b0, 1'b0, 32'h89AB_CDEF}, // R2
    '{1'b0, 3'd0, 2'd0, 32'h0000_0000, 3'd4, 2'd3, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}  // R3 R7
  };

  function automatic string vec_req(int i);
    case (i)
      0:          return "R8";
      1:          return "R1";
      2, 3:       return "R4";
      4:          return "R2";
      5, 6, 7:    return "R5";
      8:          return "R7";
      9:          return "R6";
      10:         return "R4";
      11, 12:     return "R10";
      13:         return "R3";
      14:         return "R8";
      15:         return "R2";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_sel = '0; wr_size = '0; wr_data = '0;
    rd0_sel = '0; rd0_size = '0; rd1_sel = '0; rd1_size = '0;
  endtask

  initial begin : watchdog
    #(200000 * 20ns);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    n_vec = 0;
    n_bad = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: every register reads zero after reset.
    for (int r = 0; r < 8; r++) begin
      rd0_sel = 3'(r); rd0_size = 2'd0;
      rd1_sel = 3'(r); rd1_size = 2'd1;
      #5ns;
      check("R9", "reset full view", rd0_data, 32'h0);
      check("R9", "reset half view", rd1_data, 32'h0);
      @(negedge clk);
    end

    // Vector table walk.
    for (int i = 0; i < NVEC; i++) begin
      wr_en   = VECS[i].en;
      wr_sel  = VECS[i].wsel;
      wr_size = VECS[i].wsz;
      wr_data = VECS[i].wdat;
      rd0_sel = VECS[i].rsel;
      rd0_size = VECS[i].rsz;
      rd1_sel = VECS[i].rsel;
      rd1_size = 2'd0;
      #5ns;
      check(vec_req(i), "rd0_data", rd0_data, VECS[i].exp0);
      check(vec_req(i), "rd0_err", 32'(rd0_err), 32'(VECS[i].exp0_err));
      check(vec_req(i), "wr_err", 32'(wr_err), 32'(VECS[i].exp_werr));
      check(vec_req(i), "rd1 full readback", rd1_data, VECS[i].exp1);
      @(negedge clk);
    end
    idle_inputs();

    // R7: ports decode on their own; one legal, one illegal at once.
    rd0_sel = 3'd0; rd0_size = 2'd0;
    rd1_sel = 3'd7; rd1_size = 2'd2;
    #5ns;
    check("R7", "rd0 legal while rd1 illegal", rd0_data, 32'h1234_BEEF);
    check("R7", "rd0_err low", 32'(rd0_err), 32'h0);
    check("R7", "rd1_err high", 32'(rd1_err), 32'h1);
    check("R7", "rd1 data zero", rd1_data, 32'h0);

    // R2: every register (also 4..7) accepts a half-view write.
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd6; wr_size = 2'd1; wr_data = 32'h0000_A5A5;
    @(negedge clk);
    wr_en = 1'b0;
    rd0_sel = 3'd6; rd0_size = 2'd0;
    #5ns;
    check("R2", "half write on register 6", rd0_data, 32'h0000_A5A5);

    // R9: reset asserted mid-cycle clears without waiting for an edge.
    #2ns;
    rst_n = 1'b0;
    #1ns;
    rd0_sel = 3'd0; rd0_size = 2'd0;
    rd1_sel = 3'd7; rd1_size = 2'd0;
    #1ns;
    check("R9", "async clear register 0", rd0_data, 32'h0);
    check("R9", "async clear register 7", rd1_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule